// File: doc/BRIEF.md
# Global Barrier and Interrupt Combiner

This block is one node's slice of a machine-wide barrier and interrupt network. It has four independent channels. Each channel merges a locally driven contribution with the signals arriving from six neighbouring nodes, using either a logical OR or a logical AND. The merged value is driven straight back out toward the neighbours. The merge path contains no flip-flop, so a change at any input ripples through the whole machine without waiting for a clock edge.

A channel in OR mode acts as a global interrupt: any node that raises it alerts everyone. A channel in AND mode acts as a barrier: the output rises only when every participant has raised its input. An optional sticky latch keeps a channel's output high once the merged value has been seen high in the clock domain. This lets one channel carry a complete barrier even after the participants drop their inputs.

A per-channel, per-neighbour enable mask fences a channel off at partition boundaries. A disabled neighbour is replaced by the value that cannot influence the merge. Software writes the local contributions, modes, sticky enables and masks, clears latches, and reads back synchronised channel state through a small register port.

Top module: `gbi_combiner`

## Requirements
- R1: When channel c's active mode bit is 0 (OR), ch_out[c] is 1 if the local bit is 1 or any enabled neighbour input is 1, and 0 otherwise (sticky hold aside).
- R2: When the active mode bit is 1 (AND), ch_out[c] is 1 only if the local bit is 1 and every enabled neighbour input is 1 (sticky hold aside).
- R3: A neighbour whose mask bit is 0 has no effect on the output. It stands in as 0 in OR mode and as 1 in AND mode. Neighbour n of channel c is nbr_in[c*6+n], and its mask is bit c*6+n of register 2.
- R4: ch_out follows nbr_in and the local bits with no clock edge in between.
- R5: With sticky enable set for a channel, once the merged value has been high for at least three clock edges, ch_out[c] stays 1 after the inputs fall, until the latch is cleared.
- R6: Writing 1 to bit c of address 3 clears channel c's sticky latch. With sticky enable clear, the output never holds.
- R7: The written mode, sticky enable and mask of a channel take effect only on clock edges where that channel's local bit is 0. While the local bit is 1, the previous settings stay active.
- R8: Channels are independent. Inputs or settings of one channel do not change the output of another.
- R9: Register map. Address 0 holds the local bits [3:0]. Address 1 holds the mode bits [3:0] (1 = AND) and the sticky enables [7:4]. Address 2 holds the masks [23:0]. Reading address 3 returns the two-flop synchronised merged values in [3:0] and the sticky latches in [7:4]. All other read bits are 0.
- R10: After reset, all registers read 0 and ch_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nbr_in | input | 24 | Neighbour inputs, six per channel |
| ch_out | output | 4 | Channel outputs toward neighbours |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |

## Verification
The assertions assume the neighbour inputs may change at any moment. The properties therefore only concern registered state (latches, active settings and the local bits) and the outputs those registers force. The stimulus drives register writes and neighbour changes away from the rising edge. Sticky capture is given at least four edges to pass the two synchroniser flops and the latch. Settings writes are followed by idle cycles so that the one-edge transfer from pending to active has happened before the output is sampled.

// File: rtl/gbi_pkg.sv
package gbi_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LOCAL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CONFIG = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

  typedef enum logic {MODE_OR = 1'b0, MODE_AND = 1'b1} gbi_mode_e;
endpackage

// File: rtl/gbi_sync.sv
module gbi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gbi_chan.sv
module gbi_chan
  import gbi_pkg::*;
#(
  parameter int NBR = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_and,
  input  logic           sticky_en,
  input  logic [NBR-1:0] mask,
  input  logic [NBR-1:0] nbr,
  input  logic           local_bit,
  input  logic           clr,
  output logic           out,
  output logic           merged_sync,
  output logic           sticky_q
);
  // Value a fenced-off neighbour contributes: identity of the merge operator.
  function automatic logic neutral(input logic is_and);
    return is_and;
  endfunction

  function automatic logic merge(input logic is_and, input logic lb,
                                 input logic [NBR-1:0] m, input logic [NBR-1:0] n);
    logic acc;
    acc = lb;
    for (int i = 0; i < NBR; i++) begin
      if (is_and) acc = acc & (m[i] ? n[i] : neutral(is_and));
      else        acc = acc | (m[i] ? n[i] : neutral(is_and));
    end
    return acc;
  endfunction

  logic merged;

  assign merged = merge(mode_and, local_bit, mask, nbr);

  gbi_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(merged), .q(merged_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sticky_q <= 1'b0;
    else if (clr) sticky_q <= 1'b0;
    else          sticky_q <= sticky_q | (sticky_en & merged_sync);
  end

  assign out = merged | (sticky_en & sticky_q);
endmodule

// File: rtl/gbi_regs.sv
module gbi_regs
  import gbi_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NBR = 6,
  parameter int DW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DW-1:0]      rd_data,
  input  logic [NCH-1:0]     merged_sync,
  input  logic [NCH-1:0]     sticky_q,
  output logic [NCH-1:0]     local_q,
  output logic [NCH-1:0]     act_mode,
  output logic [NCH-1:0]     act_sticky,
  output logic [NCH*NBR-1:0] act_mask,
  output logic [NCH-1:0]     clr
);
  localparam int MW = NCH * NBR;

  logic [NCH-1:0] pend_mode, pend_sticky;
  logic [MW-1:0]  pend_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_q     <= '0;
      pend_mode   <= '0;
      pend_sticky <= '0;
      pend_mask   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_LOCAL:  local_q <= wr_data[NCH-1:0];
        A_CONFIG: begin
          pend_mode   <= wr_data[NCH-1:0];
          pend_sticky <= wr_data[2*NCH-1:NCH];
        end
        A_MASK:   pend_mask <= wr_data[MW-1:0];
        default:  ;
      endcase
    end
  end

  assign clr = (wr_en && wr_addr == A_STATUS) ? wr_data[NCH-1:0] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_apply
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_mode[c]              <= 1'b0;
        act_sticky[c]            <= 1'b0;
        act_mask[c*NBR +: NBR]   <= '0;
      end else if (!local_q[c]) begin
        act_mode[c]              <= pend_mode[c];
        act_sticky[c]            <= pend_sticky[c];
        act_mask[c*NBR +: NBR]   <= pend_mask[c*NBR +: NBR];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_LOCAL:  rd_data[NCH-1:0] = local_q;
      A_CONFIG: rd_data[2*NCH-1:0] = {pend_sticky, pend_mode};
      A_MASK:   rd_data[MW-1:0] = pend_mask;
      default:  rd_data[2*NCH-1:0] = {sticky_q, merged_sync};
    endcase
  end
endmodule

// File: rtl/gbi_combiner.sv
module gbi_combiner
  import gbi_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NBR = 6,
  parameter int DW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*NBR-1:0] nbr_in,
  output logic [NCH-1:0]     ch_out,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DW-1:0]      rd_data
);
  logic [NCH-1:0]     local_q, act_mode, act_sticky, clr_w, sticky_q, merged_sync;
  logic [NCH*NBR-1:0] act_mask;

  gbi_regs #(.NCH(NCH), .NBR(NBR), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .merged_sync(merged_sync), .sticky_q(sticky_q), .local_q(local_q),
    .act_mode(act_mode), .act_sticky(act_sticky), .act_mask(act_mask),
    .clr(clr_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gbi_chan #(.NBR(NBR)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .mode_and(act_mode[c]), .sticky_en(act_sticky[c]),
      .mask(act_mask[c*NBR +: NBR]), .nbr(nbr_in[c*NBR +: NBR]),
      .local_bit(local_q[c]), .clr(clr_w[c]),
      .out(ch_out[c]), .merged_sync(merged_sync[c]), .sticky_q(sticky_q[c])
    );
  end
endmodule

// File: rtl/gbi_checker.sv
module gbi_checker #(
  parameter int NCH = 4,
  parameter int NBR = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCH-1:0]     local_q,
  input logic [NCH-1:0]     act_mode,
  input logic [NCH-1:0]     act_sticky,
  input logic [NCH*NBR-1:0] act_mask,
  input logic [NCH-1:0]     sticky_q,
  input logic [NCH-1:0]     clr_w,
  input logic [NCH-1:0]     ch_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R5
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[c] && !clr_w[c]) |=> sticky_q[c]);
    // R6
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w[c] |=> !sticky_q[c]);
    // R7
    cfg_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      local_q[c] |=> ($stable(act_mode[c]) && $stable(act_sticky[c])
                      && $stable(act_mask[c*NBR +: NBR])));
    // R1
    or_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_mode[c] && act_mask[c*NBR +: NBR] == '0 && !(act_sticky[c] && sticky_q[c]))
        |-> ch_out[c] == local_q[c]);
    // R2
    and_needs_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode[c] && !local_q[c] && !(act_sticky[c] && sticky_q[c])) |-> !ch_out[c]);
  end
endmodule

bind gbi_combiner gbi_checker #(.NCH(NCH), .NBR(NBR)) u_chk (
  .clk(clk), .rst_n(rst_n), .local_q(local_q), .act_mode(act_mode),
  .act_sticky(act_sticky), .act_mask(act_mask), .sticky_q(sticky_q),
  .clr_w(clr_w), .ch_out(ch_out)
);

// File: tb/sim_gbi_combiner.sv
module sim_gbi_combiner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] nbr_in = '0;
  logic [3:0]  ch_out;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gbi_combiner u0 (.*);

  // {mode, mask[5:0], nbr[5:0], local, expected} for channel 0
  localparam logic [14:0] VEC [11] = '{
    {1'b0, 6'h3F, 6'h00, 1'b0, 1'b0},
    {1'b0, 6'h3F, 6'h04, 1'b0, 1'b1},
    {1'b0, 6'h3F, 6'h00, 1'b1, 1'b1},
    {1'b0, 6'h00, 6'h3F, 1'b0, 1'b0},
    {1'b0, 6'h0F, 6'h30, 1'b0, 1'b0},
    {1'b1, 6'h3F, 6'h3F, 1'b1, 1'b1},
    {1'b1, 6'h3F, 6'h3E, 1'b1, 1'b0},
    {1'b1, 6'h3F, 6'h3F, 1'b0, 1'b0},
    {1'b1, 6'h0F, 6'h0F, 1'b1, 1'b1},
    {1'b1, 6'h00, 6'h00, 1'b1, 1'b1},
    {1'b1, 6'h01, 6'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  logic [31:0] r;

  initial begin
    idle(2);
    // R10 reset state
    chk("R10 out", {28'd0, ch_out}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r); chk("R10 reg", r, 32'd0);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 vector walk on channel 0
    for (int v = 0; v < 11; v++) begin
      wr(2'd0, 32'd0);
      wr(2'd1, {31'd0, VEC[v][14]});
      wr(2'd2, {26'd0, VEC[v][13:8]});
      idle(1);
      wr(2'd0, {31'd0, VEC[v][1]});
      nbr_in = {18'd0, VEC[v][7:2]};
      #1;
      chk(VEC[v][14] ? "R2/R3 and-merge" : "R1/R3 or-merge",
          {31'd0, ch_out[0]}, {31'd0, VEC[v][0]});
    end

    // R9 register readback of pending settings
    rd(2'd1, r); chk("R9 cfg read", r, 32'd1);
    rd(2'd2, r); chk("R9 mask read", r, 32'd1);

    // R4: output follows an input change between clock edges
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h00FF_FFFF);
    idle(2);
    nbr_in = '0;
    @(negedge clk); #3;
    nbr_in[2] = 1'b1; #1;
    chk("R4 async rise", {31'd0, ch_out[0]}, 32'd1);
    nbr_in[2] = 1'b0; #1;
    chk("R4 async fall", {31'd0, ch_out[0]}, 32'd0);

    // R9 status synchroniser
    nbr_in[2] = 1'b1;
    idle(3);
    rd(2'd3, r); chk("R9 status merged", r, 32'h1);
    nbr_in = '0;
    idle(3);

    // R5 sticky on channel 1 (OR)
    wr(2'd1, 32'h20);
    idle(2);
    nbr_in[6] = 1'b1;
    idle(4);
    nbr_in[6] = 1'b0; #1;
    chk("R5 sticky hold", {31'd0, ch_out[1]}, 32'd1);
    idle(3);
    chk("R5 sticky still", {31'd0, ch_out[1]}, 32'd1);
    rd(2'd3, r); chk("R5 status latch", r, 32'h20);

    // R6 clear and non-sticky channel
    wr(2'd3, 32'h2);
    #1;
    chk("R6 cleared", {31'd0, ch_out[1]}, 32'd0);
    rd(2'd3, r); chk("R6 status clear", r, 32'h0);
    nbr_in[12] = 1'b1;
    idle(4);
    nbr_in[12] = 1'b0; #1;
    chk("R6 no hold without sticky", {31'd0, ch_out[2]}, 32'd0);

    // R7 deferred settings on channel 3, R8 independence
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0);
    idle(1);
    wr(2'd0, 32'h9);
    #1;
    chk("R7 baseline", {28'd0, ch_out}, 32'h9);
    wr(2'd1, 32'h8);
    wr(2'd2, 32'hFC_0000);
    idle(3);
    chk("R7 deferred", {31'd0, ch_out[3]}, 32'd1);
    nbr_in[20] = 1'b1; #1;
    chk("R7 still OR mask0", {31'd0, ch_out[3]}, 32'd1);
    wr(2'd0, 32'h1);
    idle(2);
    nbr_in[23:18] = 6'h3F;
    wr(2'd0, 32'h9);
    #1;
    chk("R7 applied and-all", {31'd0, ch_out[3]}, 32'd1);
    nbr_in[19] = 1'b0; #1;
    chk("R7 applied and-miss", {31'd0, ch_out[3]}, 32'd0);
    chk("R8 ch0 unaffected", {31'd0, ch_out[0]}, 32'd1);
    chk("R8 ch1 ch2 idle", {30'd0, ch_out[2:1]}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule